// File: doc/BRIEF.md
# Paging I/O MMU Control and Status Core

This block is the register-facing control core of a paging I/O memory management unit. A host reaches it through a simple 32-bit register port (write strobe, byte offset, write data, combinational read data). It holds the page-directory base, the status word, a command register taking one-shot codes, the captured fault address, a single-line invalidate register, the interrupt registers (raw, clear, mask, masked) and an auto-gating configuration word.

The translation engine beside it reports page faults and bus read errors on a sideband port and tells it whether translations are in flight. In return the core drives paging enable, stall, fault hold, a whole-cache flush pulse, a single-line invalidate pulse with its address, the directory base and an interrupt line. The page walk and the translation cache storage live elsewhere.

Top module: `iommu_ctrl`

## Requirements
- R1: A write to offset 0x00 stores only bits 31:12 of the data; the low 12 bits read back as zero (0xCAFEBABE reads back 0xCAFEB000). `dir_base` shows the stored value.
- R2: Writing 0 to the command register (offset 0x08) enables paging and writing 1 disables it; paging state is status bit 0 and `paging_on`.
- R3: Command 2 requests a stall, granted only while paging is on and no fault is active. The stall becomes active on the clock edge that accepts the command if `eng_busy` is low, otherwise on the first edge where `eng_busy` is low. Status bit 2 is stall active and bit 31 is its inverse. Command 3 withdraws the stall.
- R4: While a page fault is active the stall stays inactive, and a stall request made then is refused.
- R5: A fault event (`flt_valid`) with no fault active loads the fault address register (offset 0x0C), status bit 5 (access was a write), status bits 10:6 (requesting master ID), and sets status bit 1 and raw interrupt bit 0. A fault event while a fault is active is ignored.
- R6: Command 5 clears the fault-active flag.
- R7: Raw interrupt register (offset 0x14): bit 0 page fault, bit 1 bus read error (`bus_err`). Writing 1 to a bit at offset 0x18 clears that raw bit; a new event on the same bit in the same cycle wins over the clear.
- R8: Offset 0x1C holds a 2-bit mask; offset 0x20 reads raw AND mask; `irq` is high when any masked bit is set.
- R9: Command 4 gives a one-cycle `flush_all` pulse on the cycle after the write; a write to offset 0x10 gives a one-cycle `zap_valid` pulse with `zap_addr` equal to the written data.
- R10: Command 6 returns every register to zero: directory base, paging, stall, fault state, interrupts, mask and the gating word at offset 0x24.
- R11: Status bit 3 (idle) is the inverse of `eng_busy`; status bit 4 follows `replay_empty`.
- R12: Command values other than 0 to 6 change nothing, and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| eng_busy | input | 1 | Translations in flight |
| replay_empty | input | 1 | Engine replay buffer empty |
| flt_valid | input | 1 | Page fault event from the walker |
| flt_addr | input | 32 | Faulting address |
| flt_write | input | 1 | Faulting access was a write |
| flt_id | input | 5 | Requesting bus master ID |
| bus_err | input | 1 | Bus read error event |
| paging_on | output | 1 | Translation enabled |
| stall_on | output | 1 | Engine stalled |
| fault_hold | output | 1 | Page fault pending |
| flush_all | output | 1 | Whole translation cache flush pulse |
| zap_valid | output | 1 | Single-line invalidate pulse |
| zap_addr | output | 32 | Address to invalidate |
| dir_base | output | 32 | Page directory base |
| gate_cfg | output | 32 | Auto-gating configuration |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the register port sees at most one write per cycle and that reset is applied before any traffic. They also take for granted that a clear write carrying bit 0 with no fault event in the same cycle leaves raw bit 0 low. The stimulus drives every input on the falling edge and only one write per cycle. A fault event is always followed by command 5 before the next one is expected to be taken, so the bench model never has to guess whether a fault was captured. The random phase mixes mask writes, clears, bus errors and fault events.

// File: rtl/iommu_ctrl.sv
module iommu_ctrl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          eng_busy,
  input  logic          replay_empty,
  input  logic          flt_valid,
  input  logic [31:0]   flt_addr,
  input  logic          flt_write,
  input  logic [4:0]    flt_id,
  input  logic          bus_err,
  output logic          paging_on,
  output logic          stall_on,
  output logic          fault_hold,
  output logic          flush_all,
  output logic          zap_valid,
  output logic [31:0]   zap_addr,
  output logic [31:0]   dir_base,
  output logic [31:0]   gate_cfg,
  output logic          irq
);
  localparam logic [AW-1:0] A_DIR  = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h04);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h08);
  localparam logic [AW-1:0] A_FADR = AW'(8'h0C);
  localparam logic [AW-1:0] A_ZAP  = AW'(8'h10);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h14);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h18);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h1C);
  localparam logic [AW-1:0] A_INT  = AW'(8'h20);
  localparam logic [AW-1:0] A_GATE = AW'(8'h24);

  logic        stall_want, fault_wr;
  logic [4:0]  fault_id;
  logic [31:0] fault_addr;
  logic [1:0]  raw, mask;

  wire wr_cmd = bus_wr && bus_addr == A_CMD;
  wire c_pgon = wr_cmd && bus_wdata == 32'd0;
  wire c_pgof = wr_cmd && bus_wdata == 32'd1;
  wire c_stl  = wr_cmd && bus_wdata == 32'd2;
  wire c_ustl = wr_cmd && bus_wdata == 32'd3;
  wire c_fl   = wr_cmd && bus_wdata == 32'd4;
  wire c_done = wr_cmd && bus_wdata == 32'd5;
  wire hard   = wr_cmd && bus_wdata == 32'd6;

  wire flt_take = flt_valid && !fault_hold && !hard;
  wire paging_n = hard ? 1'b0 : c_pgon ? 1'b1 : c_pgof ? 1'b0 : paging_on;
  wire fault_n  = hard ? 1'b0 : flt_take ? 1'b1 : c_done ? 1'b0 : fault_hold;
  wire want_n   = (hard || c_ustl || c_pgof || flt_take) ? 1'b0 :
                  (c_stl && paging_on && !fault_hold) ? 1'b1 : stall_want;
  wire stall_n  = want_n && !eng_busy && paging_n && !fault_n;
  wire [1:0] clr   = (bus_wr && bus_addr == A_CLR) ? bus_wdata[1:0] : 2'b00;
  wire [1:0] raw_n = hard ? 2'b00 : (raw & ~clr) | {bus_err, flt_take};
  wire [1:0] masked = raw & mask;

  assign irq = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paging_on  <= 1'b0;
      stall_want <= 1'b0;
      stall_on   <= 1'b0;
      fault_hold <= 1'b0;
      fault_wr   <= 1'b0;
      fault_id   <= '0;
      fault_addr <= '0;
      raw        <= '0;
      mask       <= '0;
      dir_base   <= '0;
      gate_cfg   <= '0;
      flush_all  <= 1'b0;
      zap_valid  <= 1'b0;
      zap_addr   <= '0;
    end else begin
      paging_on  <= paging_n;
      stall_want <= want_n;
      stall_on   <= stall_n;
      fault_hold <= fault_n;
      raw        <= raw_n;
      flush_all  <= c_fl;
      zap_valid  <= bus_wr && bus_addr == A_ZAP;
      if (bus_wr && bus_addr == A_ZAP) zap_addr <= bus_wdata;
      if (hard) begin
        fault_wr   <= 1'b0;
        fault_id   <= '0;
        fault_addr <= '0;
        mask       <= '0;
        dir_base   <= '0;
        gate_cfg   <= '0;
      end else begin
        if (flt_take) begin
          fault_wr   <= flt_write;
          fault_id   <= flt_id;
          fault_addr <= flt_addr;
        end
        if (bus_wr && bus_addr == A_MSK)  mask     <= bus_wdata[1:0];
        if (bus_wr && bus_addr == A_DIR)  dir_base <= {bus_wdata[31:12], 12'h000};
        if (bus_wr && bus_addr == A_GATE) gate_cfg <= bus_wdata;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_base;
      A_STAT:  bus_rdata = {~stall_on, 20'h0, fault_id, fault_wr, replay_empty,
                            ~eng_busy, stall_on, fault_hold, paging_on};
      A_FADR:  bus_rdata = fault_addr;
      A_RAW:   bus_rdata = {30'h0, raw};
      A_MSK:   bus_rdata = {30'h0, mask};
      A_INT:   bus_rdata = {30'h0, masked};
      A_GATE:  bus_rdata = gate_cfg;
      default: bus_rdata = 32'h0;
    endcase
  end

  assert_dir_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dir_base[11:0] == 12'h000);
  assert_no_stall_in_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hold |-> !stall_on);
  assert_fault_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hold && flt_valid && !wr_cmd) |=> $stable(fault_addr));
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR && bus_wdata[0] && !flt_valid) |=> !raw[0]);
  assert_flush_from_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> $past(c_fl));
  assert_hard_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hard |=> (dir_base == 32'h0 && !paging_on && !irq && !fault_hold));
endmodule

// File: tb/test_iommu_ctrl.sv
module test_iommu_ctrl;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic eng_busy = 0, replay_empty = 1;
  logic flt_valid = 0, flt_write = 0, bus_err = 0;
  logic [31:0] flt_addr = 0;
  logic [4:0] flt_id = 0;
  logic paging_on, stall_on, fault_hold, flush_all, zap_valid, irq;
  logic [31:0] zap_addr, dir_base, gate_cfg;
  int checks = 0, fails = 0;
  logic [31:0] r;
  logic [1:0] e_raw, e_msk;

  iommu_ctrl #(.AW(8)) i_iommu_ctrl (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic fault(input logic [31:0] a, input logic w, input logic [4:0] id);
    @(negedge clk); flt_valid = 1; flt_addr = a; flt_write = w; flt_id = id;
    @(negedge clk); flt_valid = 0;
  endtask

  function automatic logic [31:0] stat(input logic pg, input logic f, input logic st,
                                       input logic w, input logic [4:0] id);
    return {~st, 20'h0, id, w, replay_empty, ~eng_busy, st, f, pg};
  endfunction

  initial begin
    #(PERIOD*100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(PERIOD*2); @(negedge clk); rst_n = 1;
    rd(8'h04, r); chk("R11 reset status", r, 32'h8000_0018);
    chk("R10 reset dir", dir_base, 0);
    chk("R8 reset irq", {31'h0, irq}, 0);

    wr(8'h00, 32'hCAFE_BABE); rd(8'h00, r); chk("R1 dir base", r, 32'hCAFE_B000);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v = $urandom;
      wr(8'h00, v); rd(8'h00, r); chk("R1 random dir", r, v & 32'hFFFF_F000);
      chk("R1 dir port", dir_base, v & 32'hFFFF_F000);
    end

    wr(8'h08, 0); rd(8'h04, r); chk("R2 paging on", r, stat(1,0,0,0,0));
    chk("R2 paging port", {31'h0, paging_on}, 1);
    wr(8'h08, 1); rd(8'h04, r); chk("R2 paging off", r, stat(0,0,0,0,0));
    wr(8'h08, 2); rd(8'h04, r); chk("R3 stall refused w/o paging", r, stat(0,0,0,0,0));
    wr(8'h08, 0);
    wr(8'h08, 2); rd(8'h04, r); chk("R3 stall granted", r, stat(1,0,1,0,0));
    chk("R3 stall port", {31'h0, stall_on}, 1);
    wr(8'h08, 3); rd(8'h04, r); chk("R3 stall withdrawn", r, stat(1,0,0,0,0));
    eng_busy = 1;
    wr(8'h08, 2); rd(8'h04, r); chk("R3 stall waits busy / R11 idle low", r, stat(1,0,0,0,0));
    eng_busy = 0;
    @(negedge clk); rd(8'h04, r); chk("R3 stall after busy drops", r, stat(1,0,1,0,0));
    replay_empty = 0; rd(8'h04, r); chk("R11 replay empty bit", r, stat(1,0,1,0,0));
    replay_empty = 1;

    fault(32'h1234_5678, 1, 5'h15);
    rd(8'h04, r); chk("R4 R5 fault status", r, 32'h8000_057B);
    rd(8'h0C, r); chk("R5 fault addr", r, 32'h1234_5678);
    fault(32'hDEAD_0000, 0, 5'h02);
    rd(8'h0C, r); chk("R5 second fault ignored", r, 32'h1234_5678);
    rd(8'h04, r); chk("R5 status kept", r, 32'h8000_057B);
    wr(8'h08, 2); rd(8'h04, r); chk("R4 stall refused in fault", r, 32'h8000_057B);
    rd(8'h14, r); chk("R7 raw fault bit", r, 1);
    wr(8'h1C, 0); rd(8'h20, r); chk("R8 masked off", r, 0);
    chk("R8 irq masked", {31'h0, irq}, 0);
    wr(8'h1C, 1); rd(8'h20, r); chk("R8 masked on", r, 1);
    chk("R8 irq on", {31'h0, irq}, 1);
    wr(8'h08, 5); rd(8'h04, r); chk("R6 fault cleared", r, stat(1,0,0,1,5'h15));
    wr(8'h18, 1); rd(8'h14, r); chk("R7 clear", r, 0);
    fault(32'h0000_4000, 0, 1); wr(8'h08, 5);
    @(negedge clk); bus_wr = 1; bus_addr = 8'h18; bus_wdata = 1; flt_valid = 1;
    @(negedge clk); bus_wr = 0; flt_valid = 0;
    rd(8'h14, r); chk("R7 event beats clear", r, 1);
    wr(8'h08, 5); wr(8'h18, 3);

    e_raw = 0; e_msk = 1;
    for (int i = 0; i < 40; i++) begin
      int op = $urandom_range(0, 3);
      logic [1:0] v = 2'($urandom);
      case (op)
        0: begin wr(8'h1C, {30'h0, v}); e_msk = v; end
        1: begin wr(8'h18, {30'h0, v}); e_raw = e_raw & ~v; end
        2: begin @(negedge clk); bus_err = 1; @(negedge clk); bus_err = 0; e_raw[1] = 1; end
        default: begin fault($urandom, 0, 0); wr(8'h08, 5); e_raw[0] = 1; end
      endcase
      rd(8'h14, r); chk("R7 random raw", r, {30'h0, e_raw});
      rd(8'h20, r); chk("R8 random masked", r, {30'h0, e_raw & e_msk});
      chk("R8 random irq", {31'h0, irq}, {31'h0, |(e_raw & e_msk)});
    end

    wr(8'h08, 4); chk("R9 flush pulse", {31'h0, flush_all}, 1);
    @(negedge clk); chk("R9 flush one cycle", {31'h0, flush_all}, 0);
    wr(8'h10, 32'h0ABC_D000); chk("R9 zap pulse", {31'h0, zap_valid}, 1);
    chk("R9 zap addr", zap_addr, 32'h0ABC_D000);
    @(negedge clk); chk("R9 zap one cycle", {31'h0, zap_valid}, 0);

    rd(8'h04, r);
    wr(8'h08, 7); rd(8'h04, bus_wdata); chk("R12 bad code ignored", bus_wdata, r);
    rd(8'h30, r); chk("R12 unmapped read", r, 0);

    wr(8'h24, 32'h55); wr(8'h1C, 3); wr(8'h00, 32'hCAFE_BABE);
    @(negedge clk); bus_err = 1; @(negedge clk); bus_err = 0;
    wr(8'h08, 6);
    rd(8'h00, r); chk("R10 dir zero", r, 0);
    rd(8'h04, r); chk("R10 status", r, 32'h8000_0018);
    rd(8'h1C, r); chk("R10 mask", r, 0);
    rd(8'h14, r); chk("R10 raw", r, 0);
    rd(8'h24, r); chk("R10 gating", r, 0);
    rd(8'h0C, r); chk("R10 fault addr", r, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule